// File: doc/BRIEF.md
# Bus Idle Qualifier for a Consumer-Electronics Control Transmitter

This block decides when a single-wire consumer-electronics control transmitter may begin a new frame. It measures how long the open-drain bus line has stayed high. The measurement is in half nominal data-bit periods, taken from a half-period tick that a shared prescaler supplies. When a start request is pending and the idle time has reached the required amount, the block raises `tx_allowed`. The transmitter starts its frame on that qualifier and reports the start back with `frame_start`. Bit waveform generation and arbitration belong to neighbouring logic.

The required idle time comes from a 3-bit setting. A value n from 1 to 7 asks for n − 0.5 bit periods. A value of 0 leaves the choice to the hardware, based on how the previous message ended: 2.5 periods after a frame from another node, 4.5 periods after this node's own successful frame, and 6.5 periods before a retry after a failed transmission. A mode bit selects where the measurement begins. It can begin at the software start request, or automatically at the end of the previous message.

Top module: `sft_gate`

## Requirements
- R1: Out of reset `tx_allowed` and `busy` are 0, no request is pending, the previous-message context is "other node", and the idle measurement is already running from reset, so with setting 0 and mode 1 a request made after 5 high half-ticks is granted at once.
- R2: For a setting n in 1..7 the required idle time is 2n − 1 half-ticks taken with the bus high, counted from the start of the measurement.
- R3: With setting 0 the requirement is 5 half-ticks after `rx_end`, 9 after `tx_end` and 13 after `tx_fail`. When strobes coincide, `tx_fail` takes priority over `tx_end`, which takes priority over `rx_end`.
- R4: With mode bit 0 the measurement starts (from zero) on every `som_req` pulse, and end strobes do not start it.
- R5: With mode bit 1 the measurement starts (from zero) on any of `tx_end`, `rx_end`, `tx_fail`. A `som_req` does not restart it, so a request made after the idle time has already passed is granted on the next cycle.
- R6: A low bus line clears the idle count. When the line is low in the same cycle as a half-tick, the clearing wins.
- R7: `tx_allowed` is 1 exactly when a request is pending and the required idle time is met. `busy` is 1 exactly when a request is pending and the idle time is not yet met.
- R8: `frame_start` withdraws the pending request and stops the measurement until the next start event. It wins over a `som_req` in the same cycle.
- R9: The idle count saturates at its maximum, so `tx_allowed` stays 1 however many more half-ticks arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sft_cfg | input | 3 | Idle-time setting; 0 selects the hardware-chosen idle time |
| start_opt | input | 1 | 0: measure from start request; 1: measure from end of the previous message |
| som_req | input | 1 | One-cycle start-of-message request from software |
| tx_end | input | 1 | One-cycle strobe: own frame completed successfully |
| rx_end | input | 1 | One-cycle strobe: reception of another node's frame completed |
| tx_fail | input | 1 | One-cycle strobe: own transmission ended in error |
| frame_start | input | 1 | One-cycle strobe from the transmitter: the frame has begun |
| bus_line | input | 1 | Synchronised bus level (1 = released/high) |
| half_tick | input | 1 | One-cycle pulse every half nominal bit period |
| tx_allowed | output | 1 | Transmitter may start the frame |
| busy | output | 1 | A request is waiting for the bus to become free |

## Verification
Two functions of the block can fall in the same cycle. A half-tick that would bring the count to its threshold can arrive together with a low bus level. A start request can arrive together with the frame-start strobe. The bench provokes the first by driving `bus_line` low and `half_tick` high on the same edge, one tick short of the threshold. It judges the result by requiring a full fresh threshold of ticks before `tx_allowed` rises. The bench provokes the second by pulsing `som_req` and `frame_start` together. It confirms through `busy` and `tx_allowed`, both right after the pulse and after a long run of idle ticks, that no request survived.

// File: rtl/sft_pkg.sv
package sft_pkg;

    localparam int CFG_W = 3;

    // How the previous message on the bus ended
    typedef enum logic [1:0] {
        PREV_OTHER = 2'd0,
        PREV_SELF  = 2'd1,
        PREV_RETRY = 2'd2
    } prev_e;

    // Half-tick count for an explicit setting n: 2n-1
    function automatic int cfg_halves(input logic [CFG_W-1:0] cfg);
        return 2 * int'(cfg) - 1;
    endfunction

endpackage

// File: rtl/sft_history.sv
module sft_history
    import sft_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  tx_end,
    input  logic  rx_end,
    input  logic  tx_fail,
    output prev_e prev
);
    always_ff @(posedge clk) begin
        if (rst)          prev <= PREV_OTHER;
        else if (tx_fail) prev <= PREV_RETRY;
        else if (tx_end)  prev <= PREV_SELF;
        else if (rx_end)  prev <= PREV_OTHER;
    end
endmodule

// File: rtl/sft_idle_counter.sv
module sft_idle_counter #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             stop,
    input  logic             restart,
    input  logic             bus_line,
    input  logic             half_tick,
    output logic             armed,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    always_ff @(posedge clk) begin
        if (rst) begin
            armed <= 1'b1;
            cnt   <= '0;
        end else if (stop) begin
            armed <= 1'b0;
            cnt   <= '0;
        end else if (restart) begin
            armed <= 1'b1;
            cnt   <= '0;
        end else if (!bus_line) begin
            cnt   <= '0;
        end else if (armed && half_tick && cnt != CNT_MAX) begin
            cnt   <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/sft_gate.sv
module sft_gate
    import sft_pkg::*;
#(
    parameter int CNT_W     = 4,
    parameter int DEF_OTHER = 5,
    parameter int DEF_SELF  = 9,
    parameter int DEF_RETRY = 13
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CFG_W-1:0] sft_cfg,
    input  logic             start_opt,
    input  logic             som_req,
    input  logic             tx_end,
    input  logic             rx_end,
    input  logic             tx_fail,
    input  logic             frame_start,
    input  logic             bus_line,
    input  logic             half_tick,
    output logic             tx_allowed,
    output logic             busy
);
    prev_e            prev;
    logic             armed;
    logic [CNT_W-1:0] idle_cnt;
    logic             pending;
    logic             arm_evt;
    logic             met;
    int               need;

    assign arm_evt = start_opt ? (tx_end | rx_end | tx_fail) : som_req;

    sft_history u_hist (
        .clk     (clk),
        .rst     (rst),
        .tx_end  (tx_end),
        .rx_end  (rx_end),
        .tx_fail (tx_fail),
        .prev    (prev)
    );

    sft_idle_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .stop      (frame_start),
        .restart   (arm_evt),
        .bus_line  (bus_line),
        .half_tick (half_tick),
        .armed     (armed),
        .cnt       (idle_cnt)
    );

    always_comb begin
        if (sft_cfg != '0) begin
            need = cfg_halves(sft_cfg);
        end else begin
            unique case (prev)
                PREV_SELF:  need = DEF_SELF;
                PREV_RETRY: need = DEF_RETRY;
                default:    need = DEF_OTHER;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)              pending <= 1'b0;
        else if (frame_start) pending <= 1'b0;
        else if (som_req)     pending <= 1'b1;
    end

    assign met        = armed && (int'(idle_cnt) >= need);
    assign tx_allowed = pending && met;
    assign busy       = pending && !met;

endmodule

// File: rtl/sft_gate_chk.sv
module sft_gate_chk #(
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic [2:0]       sft_cfg,
    input logic             som_req,
    input logic             tx_end,
    input logic             rx_end,
    input logic             tx_fail,
    input logic             frame_start,
    input logic             bus_line,
    input logic             half_tick,
    input logic             tx_allowed,
    input logic             armed,
    input logic [CNT_W-1:0] idle_cnt
);
    // R8
    frame_clr_chk: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> !tx_allowed);

    // R6
    low_clears_chk: assert property (@(posedge clk) disable iff (rst)
        !bus_line |=> (idle_cnt == '0));

    // R8
    idle_stop_chk: assert property (@(posedge clk) disable iff (rst)
        !armed |-> (idle_cnt == '0));

    // R2
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
        (idle_cnt != $past(idle_cnt)) |->
            (idle_cnt == '0 || idle_cnt == $past(idle_cnt) + 1'b1));

    // R7
    grant_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_allowed) |-> ($past(half_tick) || $past(som_req) ||
            (sft_cfg != $past(sft_cfg)) ||
            $past(tx_end) || $past(rx_end) || $past(tx_fail)));
endmodule

bind sft_gate sft_gate_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .sft_cfg     (sft_cfg),
    .som_req     (som_req),
    .tx_end      (tx_end),
    .rx_end      (rx_end),
    .tx_fail     (tx_fail),
    .frame_start (frame_start),
    .bus_line    (bus_line),
    .half_tick   (half_tick),
    .tx_allowed  (tx_allowed),
    .armed       (armed),
    .idle_cnt    (idle_cnt)
);

// File: tb/sft_gate_tb.sv
module sft_gate_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] sft_cfg = 3'd0;
    logic       start_opt = 1'b1;
    logic       som_req = 1'b0, tx_end = 1'b0, rx_end = 1'b0, tx_fail = 1'b0;
    logic       frame_start = 1'b0, bus_line = 1'b1, half_tick = 1'b0;
    logic       tx_allowed, busy;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    sft_gate u_dut (
        .clk(clk), .rst(rst), .sft_cfg(sft_cfg), .start_opt(start_opt),
        .som_req(som_req), .tx_end(tx_end), .rx_end(rx_end), .tx_fail(tx_fail),
        .frame_start(frame_start), .bus_line(bus_line), .half_tick(half_tick),
        .tx_allowed(tx_allowed), .busy(busy)
    );

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input logic act, input logic exp, input string what);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %0b expected %0b", what, act, exp);
        end
    endtask

    task automatic tick();
        half_tick = 1'b1; cyc(); half_tick = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic go();    som_req = 1'b1;     cyc(); som_req = 1'b0;     endtask
    task automatic fstart(); frame_start = 1'b1; cyc(); frame_start = 1'b0; endtask

    // request, then sweep ticks checking the grant threshold
    task automatic sweep(input int need, input int upto, input string what);
        go();
        chk(busy, 1'b1, {what, " busy after request"});
        chk(tx_allowed, 1'b0, {what, " no grant at zero"});
        for (int k = 1; k <= upto; k++) begin
            tick();
            chk(tx_allowed, k >= need, what);
            chk(busy, k < need, {what, " busy"});
        end
        fstart();
        chk(tx_allowed, 1'b0, {what, " R8 cleared by frame start"});
    endtask

    initial begin
        #3_000_000;
        if (!done) begin
            fails++; total++;
            $display("FAIL watchdog: got hung expected finish");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        repeat (3) cyc();
        rst = 1'b0;
        // R1 reset state, measurement already running
        chk(tx_allowed, 1'b0, "R1 tx_allowed at reset");
        chk(busy, 1'b0, "R1 busy at reset");
        ticks(5);
        go();
        chk(tx_allowed, 1'b1, "R1 armed from reset, default other = 5");
        fstart();

        // R2 + R4: explicit settings, measurement from request
        start_opt = 1'b0;
        for (int n = 1; n <= 7; n++) begin
            sft_cfg = 3'(n);
            sweep(2 * n - 1, 14, "R2 explicit setting");
        end

        // R3 default-mode contexts and strobe priority
        sft_cfg = 3'd0;
        rx_end = 1'b1; cyc(); rx_end = 1'b0;
        sweep(5, 14, "R3 after rx_end");
        tx_end = 1'b1; cyc(); tx_end = 1'b0;
        sweep(9, 14, "R3 after tx_end");
        tx_fail = 1'b1; cyc(); tx_fail = 1'b0;
        sweep(13, 14, "R3 after tx_fail");
        tx_end = 1'b1; rx_end = 1'b1; cyc(); tx_end = 1'b0; rx_end = 1'b0;
        sweep(9, 12, "R3 tx_end over rx_end");
        tx_fail = 1'b1; tx_end = 1'b1; cyc(); tx_fail = 1'b0; tx_end = 1'b0;
        sweep(13, 14, "R3 tx_fail over tx_end");

        // R4: end strobes do not start count; every request restarts it
        sft_cfg = 3'd2;
        tx_end = 1'b1; cyc(); tx_end = 1'b0;
        ticks(10);
        chk(busy, 1'b0, "R4 no request pending");
        go();
        chk(tx_allowed, 1'b0, "R4 count starts at request");
        ticks(2);
        go();
        ticks(2);
        chk(tx_allowed, 1'b0, "R4 second request restarts count");
        tick();
        chk(tx_allowed, 1'b1, "R4 grant after 3 since restart");
        fstart();

        // R5: measurement from end of message
        start_opt = 1'b1; sft_cfg = 3'd3;
        rx_end = 1'b1; cyc(); rx_end = 1'b0;
        ticks(5);
        chk(busy, 1'b0, "R5 idle met, nothing pending");
        chk(tx_allowed, 1'b0, "R5 no grant without request");
        go();
        chk(tx_allowed, 1'b1, "R5 request granted at once");
        fstart();
        ticks(6);
        go();
        chk(busy, 1'b1, "R5 request does not start count");
        tx_end = 1'b1; cyc(); tx_end = 1'b0;
        ticks(4);
        chk(tx_allowed, 1'b0, "R5 4 ticks after end strobe");
        tick();
        chk(tx_allowed, 1'b1, "R5 5 ticks after end strobe");
        fstart();

        // R6: low bus restarts; low wins over a coincident tick
        start_opt = 1'b0;
        go(); ticks(4);
        bus_line = 1'b0; cyc(); bus_line = 1'b1;
        chk(tx_allowed, 1'b0, "R6 low bus clears");
        ticks(4);
        chk(tx_allowed, 1'b0, "R6 count restarted");
        tick();
        chk(tx_allowed, 1'b1, "R6 full count after low");
        fstart();
        go(); ticks(4);
        bus_line = 1'b0; half_tick = 1'b1; cyc(); bus_line = 1'b1; half_tick = 1'b0;
        chk(tx_allowed, 1'b0, "R6 low beats tick");
        chk(busy, 1'b1, "R6 still waiting");
        ticks(4);
        chk(tx_allowed, 1'b0, "R6 four after coincident low");
        tick();
        chk(tx_allowed, 1'b1, "R6 five after coincident low");
        fstart();

        // R8: frame start beats a coincident request
        som_req = 1'b1; frame_start = 1'b1; cyc(); som_req = 1'b0; frame_start = 1'b0;
        chk(busy, 1'b0, "R8 request dropped");
        chk(tx_allowed, 1'b0, "R8 no grant");
        ticks(15);
        chk(busy, 1'b0, "R8 still nothing pending");
        chk(tx_allowed, 1'b0, "R8 still no grant");

        // R9: saturation, no wrap
        sft_cfg = 3'd1;
        go();
        for (int k = 1; k <= 20; k++) begin
            tick();
            chk(tx_allowed, 1'b1, "R9 grant held through saturation");
        end
        fstart();

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule